// File: doc/BRIEF.md
# Admin Command Ring Producer

This block collects admin commands from several host functions and appends every one of them to a single circular ring held in external memory. Each command arrives as a 64-byte entry on a valid/ready stream, tagged with the number of the function that sent it. The block writes the function number into a reserved field of the entry, so software can tell the sources apart. It then issues one memory write through a simple write master and waits for the write response. Only after that response does it advance its producer index.

Software programs the ring base address, the entry count and its own consumer (read) index through a small word-addressed register port. It reads back the producer index from the same attribute layout. When software writes a newer read index, it frees slots. Each committed entry sets a status bit, and that bit can raise an interrupt. While the ring is full, or while a write is still in flight, the command stream is held off.

Top module: `admin_ring_producer`

## Requirements
- R1: After reset, `cmd_ready`, `mw_valid` and `irq` are low, and the producer index, status and enable all read as zero.
- R2: The register words are as follows. Word 0 holds base address bits 31:0. Word 1 holds base address bits 63:32. Word 2 holds the entry count in bits 15:0 and the read index in bits 31:16. Word 3 holds the producer index in bits 15:0, which is attribute bits 111:96. Word 3 is read-only, and writes to it change nothing.
- R3: The cycle after a command is accepted, `mw_valid` is high. At that point `mw_addr` equals base + producer index × 64, and `mw_data` equals the command with bits 71:64 replaced by `cmd_func`.
- R4: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold their values.
- R5: The producer index changes only on the cycle a write response is taken. It then moves to index+1, or wraps to 0 when index+1 equals the entry count.
- R6: `cmd_ready` is low in four cases: when (index+1) mod count equals the read index (ring full), when the count is below 2, while a write is outstanding, and out of reset.
- R7: Writing a new read index into word 2 frees slots, and `cmd_ready` returns.
- R8: Status word 4 bit 16 is set when an entry is committed. Software clears it by writing 1 to bit 16; writing 0 leaves it unchanged. If a commit and a clear fall in the same cycle, the set wins.
- R9: `irq` is high exactly when enable word 5 bit 16 and status bit 16 are both set.
- R10: Commands from different functions share the one ring. Each lands in the next slot in acceptance order, carrying its own function number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command entry offered |
| cmd_ready | output | 1 | Command entry taken |
| cmd_func | input | FUNC_W | Source function number |
| cmd_data | input | 512 | 64-byte command entry |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write request taken |
| mw_addr | output | ADDR_W | Byte address of ring slot |
| mw_data | output | 512 | Entry written to the slot |
| mw_resp_valid | input | 1 | Write response for the outstanding write |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency. The memory write request appears one clock after the accepting edge. The producer index and the status bit change on the edge that takes the write response, and `irq` follows on that same edge. A register write takes effect on its own edge, and reads are combinational. The bench drives inputs on falling edges and samples outputs on the next falling edge, one full register stage after the stimulus. Register reads are taken a moment after a falling edge, so no sample lands on a rising edge.

// File: rtl/arp_pkg.sv
package arp_pkg;

    localparam int ENTRY_BYTES = 64;
    localparam int ENTRY_W     = ENTRY_BYTES * 8;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam int IDX_W       = 16;   // index fields are 16 bits in the attribute layout
    localparam int REG_AW      = 3;
    localparam int IRQ_BIT     = 16;

    localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd0;
    localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd1;
    localparam logic [REG_AW-1:0] RA_IDX     = 3'd2;
    localparam logic [REG_AW-1:0] RA_PROD    = 3'd3;
    localparam logic [REG_AW-1:0] RA_STS     = 3'd4;
    localparam logic [REG_AW-1:0] RA_EN      = 3'd5;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic [63:0]      base;
        logic [IDX_W-1:0] count;
        logic [IDX_W-1:0] rd_idx;
    } ring_cfg_t;

    // Successor of a ring index for a ring of cnt slots.
    function automatic logic [IDX_W-1:0] ring_succ(input logic [IDX_W-1:0] idx,
                                                  input logic [IDX_W-1:0] cnt);
        logic [IDX_W:0] inc;
        inc = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
        if (inc == {1'b0, cnt})
            return '0;
        return inc[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/arp_regfile.sv
module arp_regfile
    import arp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              commit,
    output ring_cfg_t         cfg,
    output logic              irq
);

    ring_cfg_t cfg_q;
    logic      sts_q;
    logic      en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sts_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            if (reg_wen) begin
                case (reg_addr)
                    RA_BASE_LO: cfg_q.base[31:0]  <= reg_wdata;
                    RA_BASE_HI: cfg_q.base[63:32] <= reg_wdata;
                    RA_IDX: begin
                        cfg_q.count  <= reg_wdata[IDX_W-1:0];
                        cfg_q.rd_idx <= reg_wdata[16 +: IDX_W];
                    end
                    RA_EN:      en_q <= reg_wdata[IRQ_BIT];
                    default: ;
                endcase
            end
            if (commit)
                sts_q <= 1'b1;
            else if (reg_wen && reg_addr == RA_STS && reg_wdata[IRQ_BIT])
                sts_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BASE_LO: reg_rdata = cfg_q.base[31:0];
            RA_BASE_HI: reg_rdata = cfg_q.base[63:32];
            RA_IDX:     reg_rdata = {16'(cfg_q.rd_idx), 16'(cfg_q.count)};
            RA_PROD:    reg_rdata = {16'h0, 16'(wr_idx)};
            RA_STS:     reg_rdata[IRQ_BIT] = sts_q;
            RA_EN:      reg_rdata[IRQ_BIT] = en_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
    assign irq = sts_q & en_q;

endmodule

// File: rtl/arp_ring_state.sv
module arp_ring_state
    import arp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] count,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] wr_idx,
    output logic             has_room
);

    logic [IDX_W-1:0] wr_q;
    logic [IDX_W-1:0] succ;
    logic             usable;

    assign succ   = ring_succ(wr_q, count);
    assign usable = count > IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            wr_q <= '0;
        else if (commit)
            wr_q <= succ;
    end

    assign wr_idx   = wr_q;
    assign has_room = usable && (succ != rd_idx);

endmodule

// File: rtl/arp_writer.sv
module arp_writer
    import arp_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int FUNC_W   = 8,
    parameter int FUNC_LSB = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               has_room,
    input  logic [ADDR_W-1:0]  base,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [FUNC_W-1:0]  cmd_func,
    input  logic [ENTRY_W-1:0] cmd_data,
    output logic               mw_valid,
    input  logic               mw_ready,
    output logic [ADDR_W-1:0]  mw_addr,
    output logic [ENTRY_W-1:0] mw_data,
    input  logic               mw_resp_valid,
    output logic               commit
);

    wr_state_e          state_q;
    logic [ENTRY_W-1:0] entry_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ENTRY_W-1:0] stamped;
    logic [ADDR_W-1:0]  slot_addr;

    always_comb begin
        stamped = cmd_data;
        stamped[FUNC_LSB +: FUNC_W] = cmd_func;
    end

    assign slot_addr = base + (ADDR_W'(wr_idx) << ENTRY_SHIFT);
    assign cmd_ready = (state_q == W_IDLE) && has_room;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            entry_q <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                W_IDLE: if (cmd_valid && cmd_ready) begin
                    entry_q <= stamped;
                    addr_q  <= slot_addr;
                    state_q <= W_ISSUE;
                end
                W_ISSUE: if (mw_ready) state_q <= W_WAIT;
                W_WAIT:  if (mw_resp_valid) state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign mw_valid = (state_q == W_ISSUE);
    assign mw_addr  = addr_q;
    assign mw_data  = entry_q;
    assign commit   = (state_q == W_WAIT) && mw_resp_valid;

endmodule

// File: rtl/admin_ring_producer.sv
module admin_ring_producer
    import arp_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int FUNC_W   = 8,
    parameter int FUNC_LSB = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [FUNC_W-1:0]  cmd_func,
    input  logic [ENTRY_W-1:0] cmd_data,
    output logic               mw_valid,
    input  logic               mw_ready,
    output logic [ADDR_W-1:0]  mw_addr,
    output logic [ENTRY_W-1:0] mw_data,
    input  logic               mw_resp_valid,
    input  logic               reg_wen,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);

    ring_cfg_t        cfg;
    logic [IDX_W-1:0] wr_idx;
    logic             has_room;
    logic             commit;

    arp_regfile i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr_idx    (wr_idx),
        .commit    (commit),
        .cfg       (cfg),
        .irq       (irq)
    );

    arp_ring_state i_ring (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .count    (cfg.count),
        .rd_idx   (cfg.rd_idx),
        .wr_idx   (wr_idx),
        .has_room (has_room)
    );

    arp_writer #(
        .ADDR_W   (ADDR_W),
        .FUNC_W   (FUNC_W),
        .FUNC_LSB (FUNC_LSB)
    ) i_writer (
        .clk           (clk),
        .rst           (rst),
        .has_room      (has_room),
        .base          (cfg.base[ADDR_W-1:0]),
        .wr_idx        (wr_idx),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_func      (cmd_func),
        .cmd_data      (cmd_data),
        .mw_valid      (mw_valid),
        .mw_ready      (mw_ready),
        .mw_addr       (mw_addr),
        .mw_data       (mw_data),
        .mw_resp_valid (mw_resp_valid),
        .commit        (commit)
    );

endmodule

// File: rtl/arp_chk.sv
module arp_chk
    import arp_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic               mw_valid,
    input logic               mw_ready,
    input logic [ADDR_W-1:0]  mw_addr,
    input logic [ENTRY_W-1:0] mw_data,
    input logic               commit,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [IDX_W-1:0]   count,
    input logic [IDX_W-1:0]   rd_idx
);

    // R3
    launch_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> mw_valid);

    // R4
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    // R5
    idx_moves_on_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(wr_idx));

    // R6
    no_take_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        mw_valid |-> !cmd_ready);

    // R6
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (ring_succ(wr_idx, count) != rd_idx && count > IDX_W'(1)));

endmodule

bind admin_ring_producer arp_chk #(.ADDR_W(ADDR_W)) i_arp_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .mw_valid  (mw_valid),
    .mw_ready  (mw_ready),
    .mw_addr   (mw_addr),
    .mw_data   (mw_data),
    .commit    (commit),
    .wr_idx    (wr_idx),
    .count     (cfg.count),
    .rd_idx    (cfg.rd_idx)
);

// File: tb/test_admin_ring_producer.sv
module test_admin_ring_producer;
    import arp_pkg::*;

    localparam int ADDR_W = 64;
    localparam int FUNC_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [FUNC_W-1:0]  cmd_func = '0;
    logic [ENTRY_W-1:0] cmd_data = '0;
    logic               mw_valid;
    logic               mw_ready = 1'b0;
    logic [ADDR_W-1:0]  mw_addr;
    logic [ENTRY_W-1:0] mw_data;
    logic               mw_resp_valid = 1'b0;
    logic               reg_wen = 1'b0;
    logic [REG_AW-1:0]  reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_base;
    int          exp_wr;
    int          exp_cnt;

    always #5 clk = ~clk;

    admin_ring_producer #(.ADDR_W(ADDR_W), .FUNC_W(FUNC_W)) i_admin_ring_producer (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_func(cmd_func), .cmd_data(cmd_data),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
        .mw_resp_valid(mw_resp_valid),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    // One command through the whole write sequence.
    task automatic push(input int func, input int seed, input int stall, input int lat, input bit clr_at_resp);
        logic [ENTRY_W-1:0] d;
        logic [ENTRY_W-1:0] e;
        logic [ADDR_W-1:0]  ea;
        logic [31:0]        v;
        for (int k = 0; k < 16; k++) d[k*32 +: 32] = 32'(seed * 256 + k) ^ 32'hC300_0000;
        e = d;
        e[71:64] = 8'(func);
        ea = exp_base + 64'(exp_wr) * 64;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R6 ready with room", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1; cmd_func = 8'(func); cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(mw_valid == 1'b1, "R3 write issued", 64'(mw_valid), 64'd1);
        chk(mw_addr == ea, "R3 slot address", mw_addr, ea);
        chk(mw_data == e, "R10 entry stamped with function", mw_data[127:64], e[127:64]);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(mw_valid && mw_addr == ea && mw_data == e, "R4 held while stalled", mw_addr, ea);
            chk(cmd_ready == 1'b0, "R6 busy while in flight", 64'(cmd_ready), 64'd0);
        end
        mw_ready = 1'b1;
        @(negedge clk);
        mw_ready = 1'b0;
        chk(mw_valid == 1'b0, "R3 single write", 64'(mw_valid), 64'd0);
        repeat (lat) @(negedge clk);
        rd(RA_PROD, v);
        chk(v == 32'(exp_wr), "R5 index waits for response", 64'(v), 64'(exp_wr));
        @(negedge clk);
        mw_resp_valid = 1'b1;
        if (clr_at_resp) begin
            reg_wen = 1'b1; reg_addr = RA_STS; reg_wdata = 32'h0001_0000;
        end
        @(negedge clk);
        mw_resp_valid = 1'b0;
        reg_wen = 1'b0;
        exp_wr = (exp_wr + 1 == exp_cnt) ? 0 : exp_wr + 1;
        rd(RA_PROD, v);
        chk(v == 32'(exp_wr), "R5 index after response", 64'(v), 64'(exp_wr));
        rd(RA_STS, v);
        chk(v[16] == 1'b1, "R8 status set on commit", 64'(v[16]), 64'd1);
    endtask

    task automatic hold_off(input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        for (int c = 0; c < 3; c++) begin
            chk(cmd_ready == 1'b0, req, 64'(cmd_ready), 64'd0);
            @(negedge clk);
            chk(mw_valid == 1'b0, req, 64'(mw_valid), 64'd0);
        end
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(cmd_ready == 1'b0, "R1 cmd_ready", 64'(cmd_ready), 64'd0);
        chk(mw_valid == 1'b0, "R1 mw_valid", 64'(mw_valid), 64'd0);
        chk(irq == 1'b0, "R1 irq", 64'(irq), 64'd0);
        rd(RA_PROD, v); chk(v == 0, "R1 producer index", 64'(v), 64'd0);
        rd(RA_STS, v);  chk(v == 0, "R1 status", 64'(v), 64'd0);
        rd(RA_EN, v);   chk(v == 0, "R1 enable", 64'(v), 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        exp_base = 64'h0000_0001_0000_1000;
        exp_cnt  = 4;
        exp_wr   = 0;
        wr(RA_BASE_LO, exp_base[31:0]);
        wr(RA_BASE_HI, exp_base[63:32]);
        wr(RA_IDX, {16'd0, 16'd4});
        rd(RA_BASE_LO, v); chk(v == exp_base[31:0], "R2 base low", 64'(v), 64'(exp_base[31:0]));
        rd(RA_BASE_HI, v); chk(v == exp_base[63:32], "R2 base high", 64'(v), 64'(exp_base[63:32]));
        rd(RA_IDX, v);     chk(v == 32'h0000_0004, "R2 count and read index", 64'(v), 64'h4);
        wr(RA_PROD, 32'h0000_FFFF);
        rd(RA_PROD, v);    chk(v == 0, "R2 producer word read-only", 64'(v), 64'd0);
    endtask

    task automatic t_fill();
        push(1, 1, 0, 0, 1'b0);
        push(2, 2, 3, 2, 1'b0);
        push(3, 3, 1, 4, 1'b0);
        hold_off("R6 full ring holds off");
    endtask

    task automatic t_irq();
        logic [31:0] v;
        chk(irq == 1'b0, "R9 irq gated by enable", 64'(irq), 64'd0);
        wr(RA_EN, 32'h0001_0000);
        chk(irq == 1'b1, "R9 irq with enable and status", 64'(irq), 64'd1);
        wr(RA_STS, 32'h0000_0000);
        rd(RA_STS, v); chk(v[16] == 1'b1, "R8 writing 0 keeps status", 64'(v[16]), 64'd1);
        wr(RA_STS, 32'h0001_0000);
        rd(RA_STS, v); chk(v[16] == 1'b0, "R8 write 1 clears", 64'(v[16]), 64'd0);
        chk(irq == 1'b0, "R9 irq low after clear", 64'(irq), 64'd0);
    endtask

    task automatic t_free_wrap();
        wr(RA_IDX, {16'd2, 16'd4});
        push(5, 5, 2, 1, 1'b1);
        chk(irq == 1'b1, "R8 set wins over same-cycle clear", 64'(irq), 64'd1);
        chk(exp_wr == 0, "R5 wrap to zero", 64'(exp_wr), 64'd0);
        push(6, 6, 0, 0, 1'b0);
        hold_off("R7 ring full again at read index");
    endtask

    task automatic t_small_count();
        wr(RA_IDX, {16'd3, 16'd1});
        hold_off("R6 count below two");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_fill();
        t_irq();
        t_free_wrap();
        t_small_count();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule